// File: doc/BRIEF.md
# Way-Predicted Physically Tagged Cache Lookup

This block is the lookup path of a 16 KiB, 4-way set-associative level-1 cache with 32-byte lines, 32-bit reads and a 36-bit physical address space. The set is chosen from untranslated virtual address bits. Each way of a set keeps a short virtual hint next to its physical tag. In the first lookup stage the four hints of the set are compared with a slice of the virtual address. The single way they name is the only one whose data word is read, and that word is returned at once as a speculative result.

The physical address arrives later from a translation unit outside the block. The block then reads one physical tag, the one of the predicted way, and compares it in full to confirm or reject the hit. A rejected or absent prediction is reported as a miss, and the block raises a refill request. The refill streams the line in as eight word beats and then installs the hint, the physical tag and the valid bit in a victim way. The victim is chosen so that no two valid ways of a set ever carry the same hint.

The controller has five states. IDLE accepts a request (IDLE→LOOK on `req_valid`). LOOK matches the hints and reads the predicted word (LOOK→XLAT always). XLAT waits for translation (XLAT→CHECK on `xlat_valid`). CHECK compares the physical tag (CHECK→IDLE on a confirmed hit, CHECK→REFILL on a miss). REFILL collects the line beats (REFILL→IDLE once the last beat is accepted).

Top module: `hinted_ptag_lookup`

## Requirements
- R1: After reset every way of every set is invalid, `req_ready` is 1, and `pred_valid`, `resp_hit`, `resp_miss` and `refill_req` are 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready`) yields `pred_valid` high for exactly one cycle, starting after the second edge after acceptance. The set is virtual bits 11:5, the word within the line is bits 4:2, and the hint is bits 19:12.
- R3: `pred_hit` is 1 when a valid way of the set holds the request's hint. `pred_way` then names that way and `rd_data` is the addressed word of that way. With no match, `pred_hit`, `pred_way` and `rd_data` are all 0. These outputs hold until the next prediction.
- R4: In XLAT the block waits any number of cycles. It takes `xlat_paddr` at the first edge where `xlat_valid` is 1, and `resp_hit` or `resp_miss` pulses for one cycle after the following edge. No response appears while it waits.
- R5: `resp_hit` is 1 only when the prediction hit and the predicted way's stored physical tag equals physical bits 35:12. Otherwise `resp_miss` is 1. The two are never 1 together.
- R6: After a miss, `refill_req` is 1 and `refill_line` equals physical bits 35:5, both held until the eighth fill beat is accepted. A beat is accepted at each edge with `fill_valid` in REFILL, words 0 to 7 in order, and cycles without `fill_valid` are waited out.
- R7: The victim is the valid way whose hint equals the request's hint if one exists, else the lowest-numbered invalid way, else the way named by a round-robin pointer. The pointer is 0 at reset and advances by one after each completed refill.
- R8: No two valid ways of a set ever hold the same hint, so at most one way matches.
- R9: `req_ready` is 0 from the edge that accepts a request until the block returns to IDLE, and `req_valid` has no effect during that time.
- R10: A refill changes only the victim way of the addressed set. All other ways and sets keep their lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual byte address of the read |
| req_ready | output | 1 | Block idle and taking a request |
| pred_valid | output | 1 | One-cycle strobe for the speculative result |
| pred_hit | output | 1 | A hint matched |
| pred_way | output | 2 | Way named by the matching hint |
| rd_data | output | 32 | Word read from the predicted way |
| xlat_valid | input | 1 | Translated address present |
| xlat_paddr | input | 36 | Physical byte address of the request |
| resp_hit | output | 1 | Hit confirmed by the physical tag |
| resp_miss | output | 1 | Miss: no hint match or tag mismatch |
| refill_req | output | 1 | Line fetch requested |
| refill_line | output | 31 | Physical line address to fetch |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 32 | Fill beat word |

## Verification
Every one of the 128 sets first takes a cold miss and is then hit again, which shows that the index and word fields steer correctly and that a first fill lands in way 0. One set is filled to all four ways and read at every word offset, so hints that differ pick distinct ways. A matching hint is then paired with a foreign physical tag, which separates a confirmed hit from a bare hint match and shows the same-hint way being replaced. Pseudo-random traffic over four sets, eight hints and four tags mixes the same-hint, invalid-way and round-robin victim choices. Delayed translation, stray requests while busy and gapped fill beats show that waiting and ignored inputs leave the result unchanged.

// File: rtl/hptl_pkg.sv
package hptl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_XLAT,
        ST_CHECK,
        ST_REFILL
    } hptl_state_e;

endpackage

// File: rtl/hptl_hint_store.sv
module hptl_hint_store #(
    parameter int SETS      = 128,
    parameter int WAYS      = 4,
    parameter int HINT_BITS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(SETS)-1:0]   rd_idx,
    input  logic [HINT_BITS-1:0]      rd_hint,
    output logic [WAYS-1:0]           match_vec,
    output logic [WAYS-1:0]           valid_vec,
    input  logic                      wr_en,
    input  logic [$clog2(SETS)-1:0]   wr_idx,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [HINT_BITS-1:0]      wr_hint
);

    logic [HINT_BITS-1:0] hint_q [SETS][WAYS];
    logic [WAYS-1:0]      vld_q  [SETS];
    logic [WAYS-1:0]      dup_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            hint_q[wr_idx][wr_way] <= wr_hint;
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            match_vec[w] = vld_q[rd_idx][w] && (hint_q[rd_idx][w] == rd_hint);
            dup_vec[w]   = vld_q[wr_idx][w] && (hint_q[wr_idx][w] == wr_hint)
                           && (w != int'(wr_way));
        end
        valid_vec = vld_q[rd_idx];
    end

    // R8: a set never offers two matching ways
    p_hint_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match_vec) <= 1);

    // R8: an install never duplicates a hint held by another valid way
    p_install_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dup_vec == '0));

endmodule

// File: rtl/hptl_tag_store.sv
module hptl_tag_store #(
    parameter int SETS     = 128,
    parameter int WAYS     = 4,
    parameter int TAG_BITS = 24
) (
    input  logic                      clk,
    input  logic [$clog2(SETS)-1:0]   rd_idx,
    input  logic [$clog2(WAYS)-1:0]   rd_way,
    output logic [TAG_BITS-1:0]       rd_tag,
    input  logic                      wr_en,
    input  logic [$clog2(SETS)-1:0]   wr_idx,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [TAG_BITS-1:0]       wr_tag
);

    logic [TAG_BITS-1:0] tag_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][wr_way] <= wr_tag;
        end
    end

    assign rd_tag = tag_q[rd_idx][rd_way];

endmodule

// File: rtl/hptl_line_store.sv
module hptl_line_store #(
    parameter int SETS      = 128,
    parameter int WAYS      = 4,
    parameter int WORDS     = 8,
    parameter int DATA_BITS = 32
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [$clog2(WAYS)-1:0]     wr_way,
    input  logic [$clog2(SETS)-1:0]     wr_idx,
    input  logic [$clog2(WORDS)-1:0]    wr_word,
    input  logic [DATA_BITS-1:0]        wr_data,
    input  logic [$clog2(WAYS)-1:0]     rd_way,
    input  logic [$clog2(SETS)-1:0]     rd_idx,
    input  logic [$clog2(WORDS)-1:0]    rd_word,
    output logic [DATA_BITS-1:0]        rd_data
);

    localparam int DEPTH  = SETS * WORDS;
    localparam int A_BITS = $clog2(DEPTH);

    logic [A_BITS-1:0]    waddr;
    logic [A_BITS-1:0]    raddr;
    logic [DATA_BITS-1:0] way_rd [WAYS];

    assign waddr = {wr_idx, wr_word};
    assign raddr = {rd_idx, rd_word};

    for (genvar w = 0; w < WAYS; w++) begin : g_bank
        logic [DATA_BITS-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == ($clog2(WAYS))'(w))) begin
                mem[waddr] <= wr_data;
            end
        end

        assign way_rd[w] = mem[raddr];
    end

    assign rd_data = way_rd[rd_way];

endmodule

// File: rtl/hptl_victim_pick.sv
module hptl_victim_pick #(
    parameter int WAYS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WAYS-1:0]           valid_vec,
    input  logic [WAYS-1:0]           match_vec,
    input  logic                      advance,
    output logic [$clog2(WAYS)-1:0]   victim
);

    localparam int WAY_BITS = $clog2(WAYS);

    logic [WAY_BITS-1:0] rr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= rr_q + 1'b1;
        end
    end

    always_comb begin
        victim = rr_q;
        if (|match_vec) begin
            for (int w = 0; w < WAYS; w++) begin
                if (match_vec[w]) begin
                    victim = WAY_BITS'(w);
                end
            end
        end else begin
            for (int w = WAYS - 1; w >= 0; w--) begin
                if (!valid_vec[w]) begin
                    victim = WAY_BITS'(w);
                end
            end
        end
    end

    // R7: when a free way exists and no hint is shared, a free way is taken
    p_victim_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|match_vec) && !(&valid_vec)) |-> !valid_vec[victim]);

endmodule

// File: rtl/hinted_ptag_lookup.sv
module hinted_ptag_lookup
    import hptl_pkg::*;
#(
    parameter int CACHE_BYTES = 16384,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 32,
    parameter int WORD_BYTES  = 4,
    parameter int VA_BITS     = 32,
    parameter int PA_BITS     = 36,
    parameter int PAGE_BITS   = 12,
    parameter int HINT_BITS   = 8,
    localparam int SETS           = CACHE_BYTES / (WAYS * LINE_BYTES),
    localparam int IDX_BITS       = $clog2(SETS),
    localparam int OFF_BITS       = $clog2(LINE_BYTES),
    localparam int WOFF_BITS      = $clog2(WORD_BYTES),
    localparam int WSEL_BITS      = OFF_BITS - WOFF_BITS,
    localparam int WORDS          = LINE_BYTES / WORD_BYTES,
    localparam int WAY_BITS       = $clog2(WAYS),
    localparam int TAG_BITS       = PA_BITS - PAGE_BITS,
    localparam int DATA_BITS      = 8 * WORD_BYTES,
    localparam int LINE_ADDR_BITS = PA_BITS - OFF_BITS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [VA_BITS-1:0]         req_vaddr,
    output logic                       req_ready,
    output logic                       pred_valid,
    output logic                       pred_hit,
    output logic [WAY_BITS-1:0]        pred_way,
    output logic [DATA_BITS-1:0]       rd_data,
    input  logic                       xlat_valid,
    input  logic [PA_BITS-1:0]         xlat_paddr,
    output logic                       resp_hit,
    output logic                       resp_miss,
    output logic                       refill_req,
    output logic [LINE_ADDR_BITS-1:0]  refill_line,
    input  logic                       fill_valid,
    input  logic [DATA_BITS-1:0]       fill_data
);

    hptl_state_e state_q, state_d;

    logic [VA_BITS-1:0]   va_q;
    logic [PA_BITS-1:0]   pa_q;
    logic [IDX_BITS-1:0]  idx;
    logic [WSEL_BITS-1:0] wsel;
    logic [HINT_BITS-1:0] hint;
    logic [TAG_BITS-1:0]  ptag_in;

    logic [WAYS-1:0]      match_vec;
    logic [WAYS-1:0]      valid_vec;
    logic [WAY_BITS-1:0]  hit_way;
    logic                 hint_hit;
    logic [DATA_BITS-1:0] line_rd;
    logic [TAG_BITS-1:0]  tag_rd;
    logic [WAY_BITS-1:0]  victim;
    logic [WAY_BITS-1:0]  vict_q;
    logic [WSEL_BITS-1:0] beat_q;
    logic                 fill_take;
    logic                 commit;
    logic                 confirm;

    assign idx     = va_q[OFF_BITS +: IDX_BITS];
    assign wsel    = va_q[WOFF_BITS +: WSEL_BITS];
    assign hint    = va_q[PAGE_BITS +: HINT_BITS];
    assign ptag_in = pa_q[PAGE_BITS +: TAG_BITS];

    assign fill_take = (state_q == ST_REFILL) && fill_valid;
    assign commit    = fill_take && (beat_q == WSEL_BITS'(WORDS - 1));

    hptl_hint_store #(
        .SETS      (SETS),
        .WAYS      (WAYS),
        .HINT_BITS (HINT_BITS)
    ) u_hints (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (idx),
        .rd_hint   (hint),
        .match_vec (match_vec),
        .valid_vec (valid_vec),
        .wr_en     (commit),
        .wr_idx    (idx),
        .wr_way    (vict_q),
        .wr_hint   (hint)
    );

    hptl_tag_store #(
        .SETS     (SETS),
        .WAYS     (WAYS),
        .TAG_BITS (TAG_BITS)
    ) u_tags (
        .clk    (clk),
        .rd_idx (idx),
        .rd_way (pred_way),
        .rd_tag (tag_rd),
        .wr_en  (commit),
        .wr_idx (idx),
        .wr_way (vict_q),
        .wr_tag (ptag_in)
    );

    hptl_line_store #(
        .SETS      (SETS),
        .WAYS      (WAYS),
        .WORDS     (WORDS),
        .DATA_BITS (DATA_BITS)
    ) u_lines (
        .clk     (clk),
        .wr_en   (fill_take),
        .wr_way  (vict_q),
        .wr_idx  (idx),
        .wr_word (beat_q),
        .wr_data (fill_data),
        .rd_way  (hit_way),
        .rd_idx  (idx),
        .rd_word (wsel),
        .rd_data (line_rd)
    );

    hptl_victim_pick #(
        .WAYS (WAYS)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .match_vec (match_vec),
        .advance   (commit),
        .victim    (victim)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match_vec[w]) begin
                hit_way = WAY_BITS'(w);
            end
        end
        hint_hit = |match_vec;
    end

    assign confirm = pred_hit && valid_vec[pred_way] && (tag_rd == ptag_in);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_LOOK;
            ST_LOOK:                   state_d = ST_XLAT;
            ST_XLAT:   if (xlat_valid) state_d = ST_CHECK;
            ST_CHECK:  state_d = confirm ? ST_IDLE : ST_REFILL;
            ST_REFILL: if (commit)     state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q       <= '0;
            pa_q       <= '0;
            pred_valid <= 1'b0;
            pred_hit   <= 1'b0;
            pred_way   <= '0;
            rd_data    <= '0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            vict_q     <= '0;
            beat_q     <= '0;
        end else begin
            pred_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_miss  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q <= req_vaddr;
                    end
                end
                ST_LOOK: begin
                    pred_valid <= 1'b1;
                    pred_hit   <= hint_hit;
                    pred_way   <= hint_hit ? hit_way : '0;
                    rd_data    <= hint_hit ? line_rd : '0;
                end
                ST_XLAT: begin
                    if (xlat_valid) begin
                        pa_q <= xlat_paddr;
                    end
                end
                ST_CHECK: begin
                    resp_hit  <= confirm;
                    resp_miss <= !confirm;
                    vict_q    <= victim;
                    beat_q    <= '0;
                end
                ST_REFILL: begin
                    if (fill_valid) begin
                        beat_q <= beat_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign refill_req  = (state_q == ST_REFILL);
    assign refill_line = pa_q[OFF_BITS +: LINE_ADDR_BITS];

    // R2: the speculative strobe lasts one cycle
    p_pred_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |=> !pred_valid);

    // R9: accepting a request makes the block busy
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: hit and miss never coincide
    p_resp_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({resp_hit, resp_miss}) <= 1);

    // R5: a confirmed hit needs a hint match
    p_hit_needs_pred_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> pred_hit);

    // R6: a miss raises the refill request at once
    p_miss_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_miss |-> refill_req);

    // R6: the requested line does not move while the request stands
    p_line_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> (!refill_req || $stable(refill_line)));

    // R4: no response while translation is awaited
    p_wait_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XLAT) |-> !(resp_hit || resp_miss));

endmodule

// File: tb/hinted_ptag_lookup_test.sv
`timescale 1ns/1ps
module hinted_ptag_lookup_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        pred_valid;
    logic        pred_hit;
    logic [1:0]  pred_way;
    logic [31:0] rd_data;
    logic        xlat_valid = 1'b0;
    logic [35:0] xlat_paddr = '0;
    logic        resp_hit;
    logic        resp_miss;
    logic        refill_req;
    logic [30:0] refill_line;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit          m_valid [128][4];
    logic [7:0]  m_hint  [128][4];
    logic [23:0] m_tag   [128][4];
    int          rr = 0;

    always #2.5 clk = ~clk;

    hinted_ptag_lookup uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_way(pred_way), .rd_data(rd_data),
        .xlat_valid(xlat_valid), .xlat_paddr(xlat_paddr),
        .resp_hit(resp_hit), .resp_miss(resp_miss),
        .refill_req(refill_req), .refill_line(refill_line),
        .fill_valid(fill_valid), .fill_data(fill_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pat(input logic [23:0] tag, input logic [6:0] idx,
                                        input logic [2:0] word);
        logic [33:0] full;
        full = {tag, idx, word};
        return full[31:0] ^ 32'h5A00_0000;
    endfunction

    function automatic logic [31:0] mkva(input logic [7:0] h, input logic [6:0] idx,
                                         input logic [2:0] word);
        return {12'h000, h, idx, word, 2'b00};
    endfunction

    function automatic logic [35:0] mkpa(input logic [23:0] tag, input logic [6:0] idx);
        return {tag, idx, 5'h00};
    endfunction

    // one full transaction with expected values from the model
    task automatic lookup(input logic [31:0] va, input logic [35:0] pa,
                          input int xdly, input bit noise);
        logic [6:0]  idx;
        logic [7:0]  h;
        logic [2:0]  word;
        logic [23:0] tag;
        int          mway;
        int          vict;
        bit          exp_hit;
        idx  = va[11:5];
        h    = va[19:12];
        word = va[4:2];
        tag  = pa[35:12];
        mway = -1;
        for (int w = 0; w < 4; w++) begin
            if (m_valid[idx][w] && m_hint[idx][w] == h) mway = w;
        end
        exp_hit = (mway >= 0) && (m_tag[idx][mway] == tag);

        @(negedge clk);
        chk("R9 ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = noise;
        req_vaddr = va ^ 32'h000F_FFE0;
        chk("R9 busy after accept", req_ready, 0);
        chk("R2 no strobe in LOOK", pred_valid, 0);
        @(negedge clk);
        chk("R2 prediction strobe", pred_valid, 1);
        chk("R3 pred_hit", pred_hit, (mway >= 0));
        chk("R3 pred_way", pred_way, (mway >= 0) ? mway : 0);
        chk("R3 rd_data", rd_data, (mway >= 0) ? pat(m_tag[idx][mway], idx, word) : 32'h0);
        for (int d = 0; d < xdly; d++) begin
            @(negedge clk);
            chk("R2 strobe single cycle", pred_valid, 0);
            chk("R4 quiet while waiting", {resp_hit, resp_miss}, 0);
            chk("R9 busy while waiting", req_ready, 0);
        end
        xlat_valid = 1'b1;
        xlat_paddr = pa;
        @(negedge clk);
        xlat_valid = 1'b0;
        xlat_paddr = ~pa;
        chk("R4 no response before compare", {resp_hit, resp_miss}, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 resp_hit", resp_hit, exp_hit);
        chk("R5 resp_miss", resp_miss, !exp_hit);
        chk("R3 prediction held", pred_hit, (mway >= 0));
        if (!exp_hit) begin
            chk("R6 refill_req raised", refill_req, 1);
            chk("R6 refill_line", refill_line, pa[35:5]);
            if (mway >= 0) vict = mway;
            else begin
                vict = rr;
                for (int w = 3; w >= 0; w--) if (!m_valid[idx][w]) vict = w;
            end
            for (int b = 0; b < 8; b++) begin
                if (noise && b[0]) begin
                    fill_valid = 1'b0;
                    @(negedge clk);
                    chk("R6 waits for beat", refill_req, 1);
                end
                fill_valid = 1'b1;
                fill_data  = pat(tag, idx, 3'(b));
                @(negedge clk);
            end
            fill_valid = 1'b0;
            chk("R6 refill done", refill_req, 0);
            chk("R9 ready after refill", req_ready, 1);
            m_valid[idx][vict] = 1'b1;
            m_hint[idx][vict]  = h;
            m_tag[idx][vict]   = tag;
            rr = (rr + 1) % 4;
        end else begin
            chk("R9 ready after hit", req_ready, 1);
            chk("R6 no refill on hit", refill_req, 0);
        end
    endtask

    initial begin
        logic [31:0] seed;
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 1'b0;
                m_hint[s][w]  = '0;
                m_tag[s][w]   = '0;
            end
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 pred_valid", pred_valid, 0);
        chk("R1 resp", {resp_hit, resp_miss}, 0);
        chk("R1 refill_req", refill_req, 0);

        // R1 R7: cold miss in every set lands in way 0, then hits (R2 R3 R5)
        for (int s = 0; s < 128; s++) begin
            lookup(mkva(8'(s) ^ 8'h5A, 7'(s), 3'(s)), mkpa(24'h100000 + 24'(s * 3), 7'(s)), 0, 1'b0);
            lookup(mkva(8'(s) ^ 8'h5A, 7'(s), 3'(s + 1)), mkpa(24'h100000 + 24'(s * 3), 7'(s)), 0, 1'b0);
        end

        // R7: fill the other ways of set 9, then read every word of every way (R3)
        for (int k = 1; k < 4; k++)
            lookup(mkva(8'(k * 17), 7'd9, 3'd0), mkpa(24'h200000 + 24'(k), 7'd9), 0, 1'b0);
        for (int k = 0; k < 4; k++)
            for (int wd = 0; wd < 8; wd++) begin
                if (k == 0) lookup(mkva(8'd9 ^ 8'h5A, 7'd9, 3'(wd)), mkpa(24'h100000 + 24'd27, 7'd9), 0, 1'b0);
                else        lookup(mkva(8'(k * 17), 7'd9, 3'(wd)), mkpa(24'h200000 + 24'(k), 7'd9), 0, 1'b0);
            end

        // R5 R7: same hint, foreign tag replaces the hinted way; R10 others survive
        lookup(mkva(8'd34, 7'd9, 3'd5), mkpa(24'h3ABCDE, 7'd9), 0, 1'b0);
        lookup(mkva(8'd34, 7'd9, 3'd6), mkpa(24'h3ABCDE, 7'd9), 0, 1'b0);
        lookup(mkva(8'd17, 7'd9, 3'd2), mkpa(24'h200001, 7'd9), 0, 1'b0);
        lookup(mkva(8'd51, 7'd9, 3'd7), mkpa(24'h200003, 7'd9), 0, 1'b0);
        lookup(mkva(8'd8 ^ 8'h5A, 7'd8, 3'd1), mkpa(24'h100000 + 24'd24, 7'd8), 0, 1'b0);
        lookup(mkva(8'd10 ^ 8'h5A, 7'd10, 3'd1), mkpa(24'h100000 + 24'd30, 7'd10), 0, 1'b0);

        // R7: full set, new hints go to the round-robin way
        lookup(mkva(8'hE1, 7'd9, 3'd0), mkpa(24'h400001, 7'd9), 0, 1'b0);
        lookup(mkva(8'hE2, 7'd9, 3'd0), mkpa(24'h400002, 7'd9), 0, 1'b0);
        lookup(mkva(8'hE1, 7'd9, 3'd3), mkpa(24'h400001, 7'd9), 0, 1'b0);

        // R4 R9 R6: slow translation, stray requests, gapped fill
        lookup(mkva(8'hC3, 7'd20, 3'd4), mkpa(24'h555555, 7'd20), 5, 1'b1);
        lookup(mkva(8'hC3, 7'd20, 3'd4), mkpa(24'h555555, 7'd20), 3, 1'b1);
        lookup(mkva(8'd20 ^ 8'h5A, 7'd20, 3'd2), mkpa(24'h100000 + 24'd60, 7'd20), 1, 1'b1);

        // R7 R8 R10: mixed traffic over four sets, eight hints, four tags
        seed = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            lookup(mkva({5'b0, seed[20:18]}, {5'b0, seed[17:16]}, seed[26:24]),
                   mkpa({22'h300000, seed[23:22]}, {5'b0, seed[17:16]}),
                   int'(seed[28:27]), seed[29]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule